// File: doc/BRIEF.md
# Host Start and Completion-Poll Register Interface

This block sits between a host memory bus and a processing engine embedded in memory. It is a pure bus slave. The host launches a job by writing a start register. The written word is handed to the engine as its argument, together with a one-cycle start pulse. The block then holds a busy state until the engine raises its done input.

The host learns of completion by reading a status register. While the job is still running, that read is answered with a retry flag instead of data. The memory controller reissues the read, so host software only ever observes a completed status read. A parameterised retry budget bounds this waiting. Once the budget is spent, the next status read returns real data with a timeout bit set.

A start written while a job is running is dropped and sets a sticky error bit. A clear register resets the error and timeout bits selectively. Every request receives exactly one registered response in the following cycle, and the block never begins a transfer on its own.

Top module: `start_poll_if`

## Requirements
- R1: After reset, busy is low, no start pulse or response is driven, and a status read returns an all-zero word with no retry.
- R2: A response (rsp_valid high) appears in the cycle after, and only after, a cycle with req_valid high; the block never issues a response on its own.
- R3: A write to the start register (address 0) while idle raises eng_start for exactly one cycle, in the cycle after the write, and presents the written word on eng_arg.
- R4: A status read (address 1) while busy, before the retry budget is spent, is answered with rsp_retry high and zero data.
- R5: When eng_done is high while busy, busy clears, eng_result is captured, and the next status read returns the done bit (bit 0) set with the captured code in bits 8 upward.
- R6: A start write while busy produces no start pulse, leaves eng_arg unchanged and sets a sticky error bit (status bit 2).
- R7: After MAX_RETRY retried status reads within one job, the next status read while busy returns data without retry, with busy (bit 1) and timeout (bit 3) set. The result field keeps the last captured code.
- R8: A write to the clear register (address 2) clears the error bit when wdata bit 0 is set and the timeout bit when wdata bit 1 is set; other bits are untouched.
- R9: An accepted start clears the done bit, the timeout bit and the retry count of the previous job.
- R10: eng_done while idle is ignored; the status word does not change.
- R11: Reads of unmapped addresses return zero without retry; writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_retry | output | 1 | Reissue the request; data not valid |
| rsp_rdata | output | DATA_W | Read data |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_arg | output | DATA_W | Argument word of the accepted start |
| eng_done | input | 1 | Engine reports the job finished |
| eng_result | input | RES_W | Result code valid with eng_done |

## Verification
The bench builds the block with MAX_RETRY set to 6, a 4-bit address, a 32-bit data word and an 8-bit result code. The small budget lets the timeout boundary be reached in a few polls: the sixth retry, the first data response after it, and a later poll that must stay non-retried. Selective clearing of the error and timeout bits, and the reset of the budget by the next start, are checked against hand-computed status words.

// File: rtl/start_poll_pkg.sv
// Package: shared operation codes, register addresses and status bit
// positions for the host start/poll interface.
package start_poll_pkg;

    // Register addresses (decoded by sp_decode, relied upon by host software)
    localparam int REG_START  = 0;
    localparam int REG_STATUS = 1;
    localparam int REG_CLEAR  = 2;

    // Status word bit positions
    localparam int ST_DONE    = 0;
    localparam int ST_BUSY    = 1;
    localparam int ST_ERR     = 2;
    localparam int ST_TMO     = 3;
    localparam int ST_RES_LSB = 8;

    // Clear register bit positions
    localparam int CLR_ERR = 0;
    localparam int CLR_TMO = 1;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_START,
        OP_POLL,
        OP_CLEAR,
        OP_RD_OTHER,
        OP_WR_OTHER
    } sp_op_e;

    typedef enum logic {
        JOB_IDLE,
        JOB_RUN
    } sp_job_e;

endpackage

// File: rtl/sp_decode.sv
// Module: sp_decode
// Turns one host request into an operation code.
// Assumes: req_valid qualifies the other request fields in the same cycle.
module sp_decode
    import start_poll_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output sp_op_e            op
);

    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(REG_START);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(REG_CLEAR);

    // Classify the request by direction and address
    always_comb begin
        op = OP_NONE;
        if (req_valid) begin
            if (req_write) begin
                if (req_addr == A_START)
                    op = OP_START;
                else if (req_addr == A_CLEAR)
                    op = OP_CLEAR;
                else
                    op = OP_WR_OTHER;
            end else begin
                if (req_addr == A_STATUS)
                    op = OP_POLL;
                else
                    op = OP_RD_OTHER;
            end
        end
    end

endmodule

// File: rtl/sp_job.sv
// Module: sp_job
// Job state: accepts starts while idle, emits a one-cycle start pulse with
// the argument word, waits for the engine's done, captures its result and
// keeps the done and sticky error flags.
// Assumes: start_req and clr_err come from one decoded request, so they
// are never high together.
module sp_job
    import start_poll_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RES_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [DATA_W-1:0] start_arg,
    input  logic              clr_err,
    input  logic              eng_done,
    input  logic [RES_W-1:0]  eng_result,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [RES_W-1:0]  result,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_arg
);

    sp_job_e state_q;
    logic    finish;

    // Accept a start only while idle; finish only a running job
    always_comb begin
        accept = start_req && (state_q == JOB_IDLE);
        finish = eng_done && (state_q == JOB_RUN);
        busy   = (state_q == JOB_RUN);
    end

    // Job state transitions
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= JOB_IDLE;
        else if (accept)
            state_q <= JOB_RUN;
        else if (finish)
            state_q <= JOB_IDLE;
    end

    // One-cycle start pulse and argument register toward the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_arg   <= '0;
        end else begin
            eng_start <= accept;
            if (accept)
                eng_arg <= start_arg;
        end
    end

    // Done flag and captured result code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else if (accept) begin
            done <= 1'b0;
        end else if (finish) begin
            done   <= 1'b1;
            result <= eng_result;
        end
    end

    // Sticky error for a start written while busy
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (clr_err)
            err <= 1'b0;
        else if (start_req && (state_q == JOB_RUN))
            err <= 1'b1;
    end

endmodule

// File: rtl/sp_retry.sv
// Module: sp_retry
// Retry budget: counts status polls answered with retry during one job and
// raises a timeout flag when a poll arrives with the budget spent.
// Assumes: MAX_RETRY >= 1; the count restarts on each accepted start.
module sp_retry #(
    parameter int MAX_RETRY = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic poll,
    input  logic busy,
    input  logic clr_tmo,
    output logic retry_now,
    output logic tmo_fire,
    output logic tmo,
    output logic [$clog2(MAX_RETRY+1)-1:0] count
);

    localparam int CNT_W = $clog2(MAX_RETRY + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RETRY);

    logic budget_left;

    // Decide between retry and timeout for a poll while busy
    always_comb begin
        budget_left = (count != CNT_MAX);
        retry_now   = poll && busy && !tmo && budget_left;
        tmo_fire    = poll && busy && !tmo && !budget_left;
    end

    // Retry counter for the current job
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (accept)
            count <= '0;
        else if (retry_now)
            count <= count + 1'b1;
    end

    // Timeout flag, cleared by a new job or by the host
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo <= 1'b0;
        else if (accept || clr_tmo)
            tmo <= 1'b0;
        else if (tmo_fire)
            tmo <= 1'b1;
    end

endmodule

// File: rtl/start_poll_if.sv
// Module: start_poll_if
// Slave-only register interface: host starts an in-memory engine by writing
// the start register and polls a status register; polls during a running
// job are answered with retry until the retry budget is spent.
// Assumes: one request per cycle at most, every request is accepted, and
// the response is registered one cycle later.
module start_poll_if
    import start_poll_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int RES_W     = 8,
    parameter int MAX_RETRY = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_arg,
    input  logic              eng_done,
    input  logic [RES_W-1:0]  eng_result
);

    localparam int CNT_W = $clog2(MAX_RETRY + 1);

    sp_op_e             op;
    logic               accept;
    logic               busy_q;
    logic               done_q;
    logic               err_q;
    logic [RES_W-1:0]   result_q;
    logic               retry_now;
    logic               tmo_fire;
    logic               tmo_q;
    logic [CNT_W-1:0]   retry_cnt;
    logic               clr_err;
    logic               clr_tmo;
    logic [DATA_W-1:0]  status_word;

    // Clear-register bit selection
    always_comb begin
        clr_err = (op == OP_CLEAR) && req_wdata[CLR_ERR];
        clr_tmo = (op == OP_CLEAR) && req_wdata[CLR_TMO];
    end

    sp_decode #(.ADDR_W(ADDR_W)) dec_i (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .op        (op)
    );

    sp_job #(.DATA_W(DATA_W), .RES_W(RES_W)) job_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (op == OP_START),
        .start_arg  (req_wdata),
        .clr_err    (clr_err),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .accept     (accept),
        .busy       (busy_q),
        .done       (done_q),
        .err        (err_q),
        .result     (result_q),
        .eng_start  (eng_start),
        .eng_arg    (eng_arg)
    );

    sp_retry #(.MAX_RETRY(MAX_RETRY)) rty_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .poll      (op == OP_POLL),
        .busy      (busy_q),
        .clr_tmo   (clr_tmo),
        .retry_now (retry_now),
        .tmo_fire  (tmo_fire),
        .tmo       (tmo_q),
        .count     (retry_cnt)
    );

    // Assemble the status word, including a timeout raised by this poll
    always_comb begin
        status_word                         = '0;
        status_word[ST_DONE]                = done_q;
        status_word[ST_BUSY]                = busy_q;
        status_word[ST_ERR]                 = err_q;
        status_word[ST_TMO]                 = tmo_q || tmo_fire;
        status_word[ST_RES_LSB +: RES_W]    = result_q;
    end

    // Registered response: one per request, retry or data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_retry <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_retry <= retry_now;
            rsp_rdata <= ((op == OP_POLL) && !retry_now) ? status_word : '0;
        end
    end

endmodule

// File: rtl/start_poll_if_chk.sv
// Module: start_poll_if_chk
// Property checker bound to start_poll_if; observes ports plus the job
// busy state and retry count.
module start_poll_if_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int MAX_RETRY = 1000
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_write,
    input logic [ADDR_W-1:0]              req_addr,
    input logic                           rsp_valid,
    input logic                           rsp_retry,
    input logic [DATA_W-1:0]              rsp_rdata,
    input logic                           eng_start,
    input logic                           eng_done,
    input logic                           busy,
    input logic [$clog2(MAX_RETRY+1)-1:0] retry_cnt
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_unsolicited_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R3
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3
    start_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> ($past(req_valid) && $past(req_write) && $past(req_addr) == '0));

    // R6
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(busy));

    // R4
    retry_carries_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> (rsp_valid && rsp_rdata == '0));

    // R4
    retry_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> $past(busy));

    // R7
    retry_within_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> ($past(retry_cnt) < ($clog2(MAX_RETRY+1))'(MAX_RETRY)));

    // R5
    busy_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(eng_done));

endmodule

bind start_poll_if start_poll_if_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_RETRY (MAX_RETRY)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_retry (rsp_retry),
    .rsp_rdata (rsp_rdata),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .busy      (busy_q),
    .retry_cnt (retry_cnt)
);

// File: tb/start_poll_if_tb_top.sv
// Directed bench for start_poll_if; the engine is a stub driven by tasks.
module start_poll_if_tb_top;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int RES_W     = 8;
    localparam int MAX_RETRY = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_retry;
    logic [DATA_W-1:0] rsp_rdata;
    logic              eng_start;
    logic [DATA_W-1:0] eng_arg;
    logic              eng_done = 1'b0;
    logic [RES_W-1:0]  eng_result = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  ended    = 1'b0;

    logic              s_valid, s_retry, s_start;
    logic [DATA_W-1:0] s_rdata;

    always #4 clk = ~clk;

    start_poll_if #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W), .MAX_RETRY(MAX_RETRY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .eng_start(eng_start), .eng_arg(eng_arg),
        .eng_done(eng_done), .eng_result(eng_result)
    );

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One request; response sampled at the negedge after the capturing edge
    task automatic bus(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        s_valid = rsp_valid; s_retry = rsp_retry; s_rdata = rsp_rdata;
        s_start = eng_start;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic poll_expect(input string req, input logic exp_retry,
                               input logic [DATA_W-1:0] exp_data);
        bus(1'b0, 4'd1, '0);
        check(req, "poll rsp_valid", {31'd0, s_valid}, 32'd1);
        check(req, "poll rsp_retry", {31'd0, s_retry}, {31'd0, exp_retry});
        check(req, "poll rsp_rdata", s_rdata, exp_data);
    endtask

    task automatic engine_done(input logic [RES_W-1:0] r);
        @(negedge clk);
        eng_done = 1'b1; eng_result = r;
        @(negedge clk);
        eng_done = 1'b0; eng_result = '0;
    endtask

    task automatic t_reset;
        check("R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1", "eng_start after reset", {31'd0, eng_start}, 32'd0);
        poll_expect("R1", 1'b0, 32'h0);
        bus(1'b0, 4'd5, '0);
        check("R11", "unmapped read retry", {31'd0, s_retry}, 32'd0);
        check("R11", "unmapped read data", s_rdata, 32'h0);
    endtask

    task automatic t_start_pulse;
        bus(1'b1, 4'd0, 32'hABCD);
        check("R2", "start write rsp_valid", {31'd0, s_valid}, 32'd1);
        check("R3", "start pulse high", {31'd0, s_start}, 32'd1);
        check("R3", "eng_arg", eng_arg, 32'hABCD);
        @(negedge clk);
        check("R3", "start pulse one cycle", {31'd0, eng_start}, 32'd0);
        check("R2", "no response without request", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_poll_done;
        poll_expect("R4", 1'b1, 32'h0);
        engine_done(8'h5A);
        poll_expect("R5", 1'b0, 32'h5A01);
    endtask

    task automatic t_busy_start;
        bus(1'b1, 4'd0, 32'h1);
        check("R3", "second job pulse", {31'd0, s_start}, 32'd1);
        bus(1'b1, 4'd0, 32'h2);
        check("R6", "no pulse while busy", {31'd0, s_start}, 32'd0);
        check("R6", "eng_arg kept", eng_arg, 32'h1);
        engine_done(8'h33);
        poll_expect("R6", 1'b0, 32'h3305);
        bus(1'b1, 4'd2, 32'h1);
        poll_expect("R8", 1'b0, 32'h3301);
    endtask

    task automatic t_timeout;
        bus(1'b1, 4'd0, 32'h3);
        for (int i = 0; i < MAX_RETRY; i++)
            poll_expect("R7", 1'b1, 32'h0);
        poll_expect("R7", 1'b0, 32'h330A);
        poll_expect("R7", 1'b0, 32'h330A);
        engine_done(8'h77);
        poll_expect("R7", 1'b0, 32'h7709);
        bus(1'b1, 4'd2, 32'h1);
        poll_expect("R8", 1'b0, 32'h7709);
        bus(1'b1, 4'd2, 32'h2);
        poll_expect("R8", 1'b0, 32'h7701);
    endtask

    task automatic t_restart;
        bus(1'b1, 4'd0, 32'h4);
        poll_expect("R9", 1'b1, 32'h0);
        bus(1'b1, 4'd2, 32'h2);
        poll_expect("R9", 1'b1, 32'h0);
        engine_done(8'h11);
        poll_expect("R9", 1'b0, 32'h1101);
    endtask

    task automatic t_idle_inputs;
        engine_done(8'hEE);
        poll_expect("R10", 1'b0, 32'h1101);
        bus(1'b1, 4'd1, 32'hFFFF_FFFF);
        check("R11", "status write no pulse", {31'd0, s_start}, 32'd0);
        poll_expect("R11", 1'b0, 32'h1101);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_start_pulse;
        t_poll_done;
        t_busy_start;
        t_timeout;
        t_restart;
        t_idle_inputs;
        repeat (2) @(negedge clk);
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run;
    end

endmodule